// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides whether each core access may proceed. It holds eight programmable protection regions. Each region has a base address, a power-of-two size, a type (instruction or data), read, write and execute rights, a cache policy and a write-buffer enable. Every access presents an address, a fetch-or-data flag and a read-or-write flag. In the same cycle the block answers with a fault flag and with the cache and buffer attributes of the region that granted the access.

Regions are loaded through a one-word write port, one region per write. A region can be left dormant: it keeps its settings but grants nothing. Regions may overlap. The enabled, matching region with the highest index decides the access, even when it denies an access that a lower region would have allowed.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset every region is dormant, so every access faults and both attribute outputs are 0.
- R2: When `cfg_we` is high at a rising edge, the 33-bit `cfg_wdata` replaces the settings of region `cfg_idx`, and lookups use the new settings from that edge on. The fields are: bit 0 enable, bit 1 write-buffer enable, bit 2 cache policy (1 writeback, 0 writethrough), bit 3 execute, bit 4 write, bit 5 read, bit 6 type (1 instruction, 0 data), bits 12:7 size as log2 of the byte count, bits 32:13 base address bits 31:12.
- R3: With a size code s from 12 to 32, a region covers the 2^s bytes whose address bits 31..s equal its base. Base bits below s are ignored. Code 32 covers the whole 4 GB space.
- R4: A region whose size code lies outside 12..32 never matches any access.
- R5: A region matches only accesses of its own type. An instruction-type region matches only fetches and a data-type region matches only data accesses.
- R6: A fetch needs execute, a data read needs read and a data write needs write in the deciding region. If the right is missing, the access faults.
- R7: On a granted access, `attr_wb` carries the cache-policy bit and `attr_buf` the write-buffer bit of the deciding region. On a fault both are 0.
- R8: A region with enable 0 grants nothing while its other settings stay loaded. Writing it again with enable 1 restores its grants.
- R9: Among overlapping enabled matches, the highest region index decides, including when it denies. A dormant region never takes precedence.
- R10: An access matching no enabled region faults.
- R11: The fault and attribute outputs follow the access inputs combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 3 | Region index to write |
| cfg_wdata | input | 33 | Region settings word |
| acc_addr | input | 32 | Access address |
| acc_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| acc_write | input | 1 | 1 for a write, 0 for a read (data accesses) |
| acc_fault | output | 1 | Access denied |
| attr_wb | output | 1 | Deciding region uses writeback |
| attr_buf | output | 1 | Deciding region enables the write buffer |

## Verification
The assertions assume that the access and configuration inputs are known and stable at every rising edge after reset, and that `cfg_idx` always names an existing region. The stimulus changes every input only on the falling edge and samples the outputs one nanosecond later, so the outputs have settled before any edge. Reconfiguration is checked both just before and just after the loading edge.

// File: rtl/mpu_region_guard.sv
module mpu_region_guard #(
  parameter int NREG    = 8,
  parameter int AW      = 32,
  parameter int MIN_LOG = 12,
  localparam int IW = $clog2(NREG),
  localparam int BW = AW - MIN_LOG,
  localparam int SW = 6,
  localparam int CW = BW + SW + 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [CW-1:0] cfg_wdata,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_ifetch,
  input  logic          acc_write,
  output logic          acc_fault,
  output logic          attr_wb,
  output logic          attr_buf
);

  localparam int B_EN = 0, B_BUF = 1, B_WB = 2, B_X = 3, B_W = 4, B_R = 5, B_TY = 6;
  localparam int S_LO = 7, S_HI = S_LO + SW - 1;

  logic [CW-1:0]   cfg_q [NREG];
  logic [NREG-1:0] rg_match;
  logic [IW-1:0]   win_idx;
  logic            win_any;
  logic            need_ok;
  logic            granted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cfg_q[i] <= '0;
    end else if (cfg_we) begin
      cfg_q[cfg_idx] <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rg
    logic [SW-1:0] sz;
    logic          sz_ok;
    logic [AW-1:0] mask;
    logic [AW-1:0] base_addr;
    assign sz        = cfg_q[g][S_HI:S_LO];
    assign sz_ok     = (sz >= SW'(MIN_LOG)) && (sz <= SW'(AW));
    assign mask      = sz_ok ? ~((AW'(1) << sz) - AW'(1)) : '0;
    assign base_addr = {cfg_q[g][CW-1:S_HI+1], {MIN_LOG{1'b0}}};
    assign rg_match[g] = cfg_q[g][B_EN] && sz_ok &&
                         (cfg_q[g][B_TY] == acc_ifetch) &&
                         (((acc_addr ^ base_addr) & mask) == '0);
  end

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rg_match[i]) begin
        win_any = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  assign need_ok   = acc_ifetch ? cfg_q[win_idx][B_X] :
                     acc_write  ? cfg_q[win_idx][B_W] : cfg_q[win_idx][B_R];
  assign granted   = win_any && need_ok;
  assign acc_fault = !granted;
  assign attr_wb   = granted && cfg_q[win_idx][B_WB];
  assign attr_buf  = granted && cfg_q[win_idx][B_BUF];

  AST_CFG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q[$past(cfg_idx)] == $past(cfg_wdata)); // R2
  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fault |-> cfg_q[win_idx][B_EN]); // R8
  AST_GRANT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fault |-> (cfg_q[win_idx][B_TY] == acc_ifetch)); // R5
  AST_GRANT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_fault && acc_write && !acc_ifetch) |-> cfg_q[win_idx][B_W]); // R6
  AST_GRANT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fault |-> (cfg_q[win_idx][S_HI:S_LO] >= SW'(MIN_LOG) &&
                    cfg_q[win_idx][S_HI:S_LO] <= SW'(AW))); // R4
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> (!attr_wb && !attr_buf)); // R7

endmodule

// File: tb/sim_mpu_region_guard.sv
module sim_mpu_region_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [32:0] cfg_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_ifetch = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_fault, attr_wb, attr_buf;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mpu_region_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_ifetch(acc_ifetch),
    .acc_write(acc_write), .acc_fault(acc_fault), .attr_wb(attr_wb),
    .attr_buf(attr_buf));

  function automatic logic [32:0] mk(input logic [31:0] base, input int sz,
      input bit ty, input bit r, input bit w, input bit x,
      input bit wb, input bit bf, input bit en);
    return {base[31:12], 6'(sz), ty, r, w, x, wb, bf, en};
  endfunction

  task automatic chk(input string tag, input bit ef, input bit ew, input bit eb);
    nchk++;
    if (acc_fault !== ef || attr_wb !== ew || attr_buf !== eb) begin
      nfail++;
      $display("FAIL %s: got fault=%b wb=%b buf=%b, expected fault=%b wb=%b buf=%b",
               tag, acc_fault, attr_wb, attr_buf, ef, ew, eb);
    end
  endtask

  task automatic wr(input int idx, input logic [32:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input bit f, input bit w);
    @(negedge clk);
    acc_addr = a; acc_ifetch = f; acc_write = w;
    #1;
  endtask

  task automatic t_reset;
    acc(32'h0000_0000, 0, 0); chk("R1 data read after reset", 1, 0, 0);
    acc(32'h0001_0000, 1, 0); chk("R1 fetch after reset", 1, 0, 0);
  endtask

  task automatic t_basic;
    wr(0, mk(32'h0001_0000, 16, 0, 1, 1, 0, 1, 1, 1));
    acc(32'h0001_1234, 0, 0); chk("R3 R7 read inside 64KB", 0, 1, 1);
    acc(32'h0001_FFFF, 0, 1); chk("R3 write at top byte", 0, 1, 1);
    acc(32'h0002_0000, 0, 0); chk("R10 just above region", 1, 0, 0);
    acc(32'h0001_1234, 1, 0); chk("R5 fetch into data region", 1, 0, 0);
  endtask

  task automatic t_perm;
    wr(1, mk(32'h2000_0000, 12, 0, 1, 0, 0, 0, 1, 1));
    acc(32'h2000_0004, 0, 1); chk("R6 write to read-only", 1, 0, 0);
    acc(32'h2000_0004, 0, 0); chk("R6 R7 read read-only", 0, 0, 1);
    acc(32'h2000_1000, 0, 0); chk("R3 past 4KB", 1, 0, 0);
  endtask

  task automatic t_instr;
    wr(2, mk(32'h0800_0000, 20, 1, 0, 0, 1, 1, 0, 1));
    acc(32'h080F_FFFC, 1, 0); chk("R5 fetch in code region", 0, 1, 0);
    acc(32'h080F_FFFC, 0, 0); chk("R5 data read in code region", 1, 0, 0);
    acc(32'h0810_0000, 1, 0); chk("R3 fetch past 1MB", 1, 0, 0);
  endtask

  task automatic t_align;
    wr(3, mk(32'h3000_5000, 16, 0, 1, 0, 0, 1, 1, 1));
    acc(32'h3000_0000, 0, 0); chk("R3 base low bits ignored (low)", 0, 1, 1);
    acc(32'h3000_FFFF, 0, 0); chk("R3 base low bits ignored (high)", 0, 1, 1);
  endtask

  task automatic t_badsize;
    wr(4, mk(32'h4000_0000, 11, 0, 1, 1, 1, 1, 1, 1));
    acc(32'h4000_0000, 0, 0); chk("R4 size 11 never matches", 1, 0, 0);
    wr(4, mk(32'h4000_0000, 33, 0, 1, 1, 1, 1, 1, 1));
    acc(32'h4000_0000, 0, 0); chk("R4 size 33 never matches", 1, 0, 0);
    wr(4, mk(32'h4000_0000, 63, 0, 1, 1, 1, 1, 1, 1));
    acc(32'h9000_0000, 0, 0); chk("R4 size 63 never matches", 1, 0, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd4; cfg_wdata = mk(32'h5000_0000, 12, 0, 1, 0, 0, 1, 0, 1);
    acc_addr = 32'h5000_0000; acc_ifetch = 1'b0; acc_write = 1'b0;
    #1; chk("R2 not yet loaded before edge", 1, 0, 0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    #1; chk("R2 R11 loaded after edge", 0, 1, 0);
    acc_addr = 32'h5000_1000;
    #1; chk("R11 address change mid-cycle", 1, 0, 0);
  endtask

  task automatic t_whole;
    wr(5, mk(32'h0000_0000, 32, 0, 1, 0, 0, 1, 0, 1));
    acc(32'hFFFF_FFF0, 0, 0); chk("R3 size 32 covers top", 0, 1, 0);
    acc(32'h0001_1234, 0, 0); chk("R9 whole-space region 5 wins", 0, 1, 0);
    acc(32'h0001_1234, 0, 1); chk("R9 region 5 denies write", 1, 0, 0);
    wr(5, mk(32'h0000_0000, 32, 0, 1, 0, 0, 1, 0, 0));
    acc(32'hFFFF_FFF0, 0, 0); chk("R8 region 5 dormant", 1, 0, 0);
  endtask

  task automatic t_dormant;
    wr(0, mk(32'h0001_0000, 16, 0, 1, 1, 0, 1, 1, 0));
    acc(32'h0001_1234, 0, 0); chk("R8 dormant region 0 denies", 1, 0, 0);
    wr(0, mk(32'h0001_0000, 16, 0, 1, 1, 0, 1, 1, 1));
    acc(32'h0001_1234, 0, 0); chk("R8 region 0 re-enabled", 0, 1, 1);
  endtask

  task automatic t_prio;
    wr(6, mk(32'h0001_0000, 12, 0, 1, 0, 0, 0, 0, 1));
    acc(32'h0001_0010, 0, 0); chk("R9 region 6 decides read", 0, 0, 0);
    acc(32'h0001_0010, 0, 1); chk("R9 region 6 denies write", 1, 0, 0);
    acc(32'h0001_1010, 0, 1); chk("R9 region 0 outside overlap", 0, 1, 1);
    wr(7, mk(32'h0001_0000, 12, 0, 1, 1, 0, 1, 1, 0));
    acc(32'h0001_0010, 0, 0); chk("R9 dormant region 7 no precedence", 0, 0, 0);
    acc(32'h0001_0010, 0, 1); chk("R9 dormant region 7 write still denied", 1, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_perm();
    t_instr();
    t_align();
    t_badsize();
    t_timing();
    t_whole();
    t_dormant();
    t_prio();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule